// File: doc/BRIEF.md
# MDIO Management Master with Host Registers

This block runs single Clause 22 management frames on an MDIO bus for a host that sees three 16-bit registers. The host first places the outgoing value in the write-data register. It then writes the control register with a PHY address, a PHY register number and a command code. That one control write both chooses the operation and launches it. While the frame runs, an idle flag in the control register reads 0. After a read frame, the 16 bits returned by the PHY are held in the read-data register.

The serial side has an MDC clock output and a split MDIO pad: output value, output enable and input. MDC comes from the system clock through a divider parameter. The default suits a 200 MHz system clock with MDC at 2.5 MHz or below. A whole 64-bit frame therefore takes 2 × HALF_DIV × 64 system clocks. With the defaults that is 25.6 µs.

Top module: `mdio_host_master`

## Requirements
- R1: After reset the control register reads 0x1000, meaning idle = 1 and every other bit is 0. The write-data and read-data registers read 0, MDC is low and the MDIO output enable is low. Whenever the engine is idle, MDC stays low and the output enable stays low.
- R2: The host address selects the register: 0 is control, 1 is write data, 2 is read data, and 3 reads as 0. Control holds the PHY register number in bits 4:0, the PHY address in bits 9:5, the command in bits 11:10 and the idle flag in bit 12. The fields of the last accepted command read back. The write-data register reads back the value last written to it.
- R3: A control write made while idle with command 1 starts a write frame, and with command 2 starts a read frame. Commands 0 and 3 start nothing: MDC does not toggle, idle stays 1 and the control fields do not change.
- R4: Each frame is 64 bits, sent MSB first: 32 ones, then 0,1, then opcode 1,0 for a read or 0,1 for a write, then the 5-bit PHY address, the 5-bit register number, 2 turnaround bits and 16 data bits. On a write frame the turnaround bits are 1,0.
- R5: MDC has a period of 2 × HALF_DIV system clocks and starts each bit low. MDIO output changes only on the falling edge of MDC. MDIO input is sampled on the rising edge of MDC.
- R6: On a read frame the output enable drops to 0 from frame bit 46 (the first turnaround bit) through bit 63. On a write frame it stays at 1 for all 64 bits.
- R7: When a read frame completes, the 16 data bits sampled from the PHY, first-received as MSB, appear in the read-data register.
- R8: A control write made while the engine is busy is ignored. The running frame continues unchanged, no second frame follows, and the control fields do not change.
- R9: Idle reads 0 from the clock after a command is accepted until the falling MDC edge that ends bit 63. Idle reads 1 one system clock after that edge.
- R10: The 16 data bits of a write frame are the contents of the write-data register at the moment the command is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| host_wr | input | 1 | Host register write strobe, one clock per write |
| host_addr | input | 2 | Register select: 0 control, 1 write data, 2 read data |
| host_wdata | input | 16 | Host write value |
| host_rdata | output | 16 | Register contents at host_addr (combinational) |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable (1 = drive) |
| mdio_i | input | 1 | MDIO input from the pad |

## Verification
The assertions assume that host_wr is a single-clock strobe and that the PHY holds mdio_i stable across each rising MDC edge. The bench meets both conditions. It pulses the write strobe between falling clock edges, and its PHY model changes mdio_i only just after a falling MDC edge. The assertions also assume that no command can arrive while a frame is finishing. The bench keeps to this because it waits for the idle flag before each new command, except for the one deliberate write it issues while busy. The reset-release window is excluded by the reset condition on every property.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

  localparam int REG_W    = 16;
  localparam int FIELD_W  = 5;
  localparam int IDLE_BIT = 12;

  localparam logic [1:0] ADR_CTRL  = 2'd0;
  localparam logic [1:0] ADR_WDATA = 2'd1;
  localparam logic [1:0] ADR_RDATA = 2'd2;

  typedef enum logic [1:0] {
    CMD_NONE  = 2'd0,
    CMD_WRITE = 2'd1,
    CMD_READ  = 2'd2,
    CMD_RSVD  = 2'd3
  } mdio_cmd_e;

  typedef struct packed {
    logic [FIELD_W-1:0] phy;
    logic [FIELD_W-1:0] regn;
    logic               is_read;
    logic [REG_W-1:0]   wdata;
  } mdio_req_t;

endpackage

// File: rtl/mdio_clk_div.sv
module mdio_clk_div #(
  parameter int HALF_DIV = 40
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic mdc,
  output logic rise_stb,
  output logic fall_stb
);

  localparam int CW = (HALF_DIV > 2) ? $clog2(HALF_DIV) : 1;
  localparam logic [CW-1:0] TERM = CW'(HALF_DIV - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          mdc_q, mdc_d;
  logic          tick;

  always_comb begin
    tick     = run && (cnt_q == TERM);
    rise_stb = tick && !mdc_q;
    fall_stb = tick && mdc_q;
    if (!run || tick) cnt_d = '0;
    else              cnt_d = cnt_q + 1'b1;
    if (!run)      mdc_d = 1'b0;
    else if (tick) mdc_d = ~mdc_q;
    else           mdc_d = mdc_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      mdc_q <= mdc_d;
    end
  end

  assign mdc = mdc_q;

  AST_MDC_HALF_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(mdc_q) || $fell(mdc_q)) |-> ($past(cnt_q) == TERM)); // R5

endmodule

// File: rtl/mdio_frame_eng.sv
module mdio_frame_eng
  import mdio_pkg::*;
#(
  parameter int PRE_LEN = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  mdio_req_t        req,
  input  logic             rise_stb,
  input  logic             fall_stb,
  input  logic             mdio_i,
  output logic             busy,
  output logic             run,
  output logic             mdio_o,
  output logic             mdio_oe,
  output logic             rd_done,
  output logic [REG_W-1:0] rd_word
);

  localparam int FRAME_LEN = PRE_LEN + 4 + 2 * FIELD_W + 2 + REG_W;
  localparam int IDX_W     = $clog2(FRAME_LEN);
  localparam logic [IDX_W-1:0] TA_IDX   = IDX_W'(FRAME_LEN - REG_W - 2);
  localparam logic [IDX_W-1:0] DATA_IDX = IDX_W'(FRAME_LEN - REG_W);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_LEN - 1);

  logic                 busy_q, busy_d;
  logic                 fin_q, fin_d;
  logic                 rd_q, rd_d;
  logic                 oe_q, oe_d;
  logic                 done_q, done_d;
  logic [IDX_W-1:0]     idx_q, idx_d, idx_nxt;
  logic [FRAME_LEN-1:0] sreg_q, sreg_d, frame;
  logic [REG_W-1:0]     cap_q, cap_d;
  logic [1:0]           opc;

  always_comb begin
    opc     = req.is_read ? 2'b10 : 2'b01;
    frame   = {{PRE_LEN{1'b1}}, 2'b01, opc, req.phy, req.regn, 2'b10, req.wdata};
    idx_nxt = idx_q + 1'b1;
    busy_d  = busy_q;
    fin_d   = fin_q;
    rd_d    = rd_q;
    oe_d    = oe_q;
    idx_d   = idx_q;
    sreg_d  = sreg_q;
    cap_d   = cap_q;
    done_d  = 1'b0;
    if (start && !busy_q) begin
      busy_d = 1'b1;
      fin_d  = 1'b0;
      rd_d   = req.is_read;
      oe_d   = 1'b1;
      idx_d  = '0;
      sreg_d = frame;
      cap_d  = '0;
    end else if (fin_q) begin
      busy_d = 1'b0;
      fin_d  = 1'b0;
      done_d = rd_q;
    end else if (busy_q) begin
      if (rise_stb && rd_q && (idx_q >= DATA_IDX))
        cap_d = {cap_q[REG_W-2:0], mdio_i};
      if (fall_stb) begin
        if (idx_q == LAST_IDX) begin
          fin_d = 1'b1;
          oe_d  = 1'b0;
        end else begin
          idx_d  = idx_nxt;
          sreg_d = {sreg_q[FRAME_LEN-2:0], 1'b0};
          if (rd_q && (idx_nxt >= TA_IDX)) oe_d = 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      fin_q  <= 1'b0;
      rd_q   <= 1'b0;
      oe_q   <= 1'b0;
      done_q <= 1'b0;
      idx_q  <= '0;
      sreg_q <= '0;
      cap_q  <= '0;
    end else begin
      busy_q <= busy_d;
      fin_q  <= fin_d;
      rd_q   <= rd_d;
      oe_q   <= oe_d;
      done_q <= done_d;
      idx_q  <= idx_d;
      sreg_q <= sreg_d;
      cap_q  <= cap_d;
    end
  end

  assign busy    = busy_q;
  assign run     = busy_q && !fin_q;
  assign mdio_o  = sreg_q[FRAME_LEN-1];
  assign mdio_oe = oe_q;
  assign rd_done = done_q;
  assign rd_word = cap_q;

  AST_READ_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && rd_q && (idx_q >= TA_IDX)) |-> !oe_q); // R6
  AST_IDLE_UNDRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q |-> !oe_q); // R1
  AST_FINISH_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    fin_q |=> !busy_q); // R9
  AST_SHIFT_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && $past(busy_q) && !$stable(sreg_q[FRAME_LEN-1])) |-> $past(fall_stb)); // R5

endmodule

// File: rtl/mdio_host_master.sv
module mdio_host_master
  import mdio_pkg::*;
#(
  parameter int HALF_DIV = 40,
  parameter int PRE_LEN  = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        host_wr,
  input  logic [1:0]  host_addr,
  input  logic [15:0] host_wdata,
  output logic [15:0] host_rdata,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);

  logic [1:0]         rst_sync_q;
  logic               rst_i;
  logic [REG_W-1:0]   wdata_q, wdata_d;
  logic [REG_W-1:0]   rdata_q, rdata_d;
  logic [FIELD_W-1:0] phy_q, phy_d;
  logic [FIELD_W-1:0] regn_q, regn_d;
  logic [1:0]         cmd_q, cmd_d;
  logic               ctrl_wr, cmd_ok, accept;
  logic               busy, run, rise_stb, fall_stb, rd_done;
  logic [REG_W-1:0]   rd_word;
  mdio_req_t          req;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i = rst_sync_q[1];

  always_comb begin
    ctrl_wr = host_wr && (host_addr == ADR_CTRL);
    cmd_ok  = (host_wdata[11:10] == CMD_WRITE) || (host_wdata[11:10] == CMD_READ);
    accept  = ctrl_wr && cmd_ok && !busy;
    wdata_d = (host_wr && (host_addr == ADR_WDATA)) ? host_wdata : wdata_q;
    rdata_d = rd_done ? rd_word : rdata_q;
    phy_d   = accept ? host_wdata[9:5]   : phy_q;
    regn_d  = accept ? host_wdata[4:0]   : regn_q;
    cmd_d   = accept ? host_wdata[11:10] : cmd_q;
    req.phy     = host_wdata[9:5];
    req.regn    = host_wdata[4:0];
    req.is_read = (host_wdata[11:10] == CMD_READ);
    req.wdata   = wdata_q;
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      wdata_q <= '0;
      rdata_q <= '0;
      phy_q   <= '0;
      regn_q  <= '0;
      cmd_q   <= '0;
    end else begin
      wdata_q <= wdata_d;
      rdata_q <= rdata_d;
      phy_q   <= phy_d;
      regn_q  <= regn_d;
      cmd_q   <= cmd_d;
    end
  end

  always_comb begin
    case (host_addr)
      ADR_CTRL:  host_rdata = {3'b000, !busy, cmd_q, phy_q, regn_q};
      ADR_WDATA: host_rdata = wdata_q;
      ADR_RDATA: host_rdata = rdata_q;
      default:   host_rdata = '0;
    endcase
  end

  mdio_clk_div #(.HALF_DIV(HALF_DIV)) u_div (
    .clk      (clk),
    .rst_n    (rst_i),
    .run      (run),
    .mdc      (mdc),
    .rise_stb (rise_stb),
    .fall_stb (fall_stb)
  );

  mdio_frame_eng #(.PRE_LEN(PRE_LEN)) u_eng (
    .clk      (clk),
    .rst_n    (rst_i),
    .start    (accept),
    .req      (req),
    .rise_stb (rise_stb),
    .fall_stb (fall_stb),
    .mdio_i   (mdio_i),
    .busy     (busy),
    .run      (run),
    .mdio_o   (mdio_o),
    .mdio_oe  (mdio_oe),
    .rd_done  (rd_done),
    .rd_word  (rd_word)
  );

  AST_BUSY_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_i)
    (ctrl_wr && busy) |=> ($stable(phy_q) && $stable(regn_q) && $stable(cmd_q))); // R8
  AST_NOP_NO_START: assert property (@(posedge clk) disable iff (!rst_i)
    (ctrl_wr && !busy && !cmd_ok) |=> !busy); // R3
  AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_i)
    accept |=> busy); // R9
  AST_IDLE_MDC_LOW: assert property (@(posedge clk) disable iff (!rst_i)
    !busy |-> !mdc); // R1
  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_i)
    !rd_done |=> $stable(rdata_q)); // R7

endmodule

// File: tb/sim_mdio_host_master.sv
`timescale 1ns/100ps
module sim_mdio_host_master;

  localparam int HALF = 40;

  typedef struct packed {logic oe; logic val;} bit_exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_wr = 1'b0;
  logic [1:0]  host_addr = 2'd0;
  logic [15:0] host_wdata = 16'h0;
  logic [15:0] host_rdata;
  logic        mdc, mdio_o, mdio_oe;
  logic        mdio_i = 1'b1;

  int vectors = 0;
  int miscompares = 0;
  int rises = 0;
  int cyc = 0;
  int last_rise = 0;
  bit finished = 0;
  logic        phy_drive = 1'b0;
  logic [15:0] phy_val = 16'h0;
  bit_exp_t    exp_q[$];

  mdio_host_master #(.HALF_DIV(HALF), .PRE_LEN(32)) u0 (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .mdc(mdc),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc++;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] expv);
    vectors++;
    if (act !== expv) begin
      miscompares++;
      $display("FAIL %s actual %h expected %h", req, act, expv);
    end
  endtask

  task automatic host_write(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    host_wr = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic host_read(input logic [1:0] a, output logic [15:0] d);
    host_addr = a;
    #1;
    d = host_rdata;
  endtask

  // Monitor: pops expected bits at each rising MDC edge (R4, R5, R6)
  always @(posedge mdc) begin
    #1;
    rises++;
    if (rises > 1) chk("R5 mdc period", cyc - last_rise, 2 * HALF);
    last_rise = cyc;
    if (exp_q.size() == 0) begin
      chk("R8 unexpected mdc bit", 1, 0);
    end else begin
      bit_exp_t e;
      e = exp_q.pop_front();
      chk("R6 output enable", mdio_oe, e.oe);
      if (e.oe) chk("R4 frame bit", mdio_o, e.val);
    end
  end

  // PHY model: drives read data after falling MDC edges
  always @(negedge mdc) begin
    #1;
    if (phy_drive && rises >= 48 && rises <= 63) mdio_i = phy_val[63 - rises];
    else mdio_i = 1'b1;
  end

  // Driver: pushes expected frame, launches it, checks completion
  task automatic run_frame(input bit is_read, input logic [4:0] phy, input logic [4:0] rn,
                           input logic [15:0] wd, input logic [15:0] rv, input bit inject);
    logic [63:0] fr;
    logic [15:0] d;
    logic [1:0]  cmd;
    cmd = is_read ? 2'd2 : 2'd1;
    if (!is_read) host_write(2'd1, wd);
    fr = {32'hFFFF_FFFF, 2'b01, (is_read ? 2'b10 : 2'b01), phy, rn, 2'b10,
          (is_read ? 16'h0 : wd)};
    for (int k = 0; k < 64; k++) begin
      bit_exp_t e;
      e.val = fr[63 - k];
      e.oe  = !(is_read && k >= 46);
      exp_q.push_back(e);
    end
    phy_val = rv; phy_drive = is_read; rises = 0;
    host_write(2'd0, {3'b000, 1'b0, cmd, phy, rn});
    host_read(2'd0, d);
    chk("R9 idle low while busy", d[12], 1'b0);
    if (inject) begin
      host_write(2'd0, {3'b000, 1'b0, 2'd2, ~phy, ~rn});
      host_read(2'd0, d);
      chk("R8 fields unchanged by busy write", d[11:0], {cmd, phy, rn});
    end
    repeat (64) @(negedge mdc);
    #1;
    host_read(2'd0, d);
    chk("R9 idle still 0 at last fall", d[12], 1'b0);
    @(posedge clk);
    #1;
    host_read(2'd0, d);
    chk("R9 idle 1 one clock later", d[12], 1'b1);
    chk("R2 control readback", d, {3'b000, 1'b1, cmd, phy, rn});
    chk("R4 all bits consumed", exp_q.size(), 0);
    repeat (3 * HALF) @(posedge clk);
    #1;
    chk("R8 no second frame", rises, 64);
    if (is_read) begin
      host_read(2'd2, d);
      chk("R7 read data", d, rv);
    end
    phy_drive = 1'b0;
  endtask

  initial begin
    logic [15:0] d;
    repeat (4) @(posedge clk);
    #1;
    chk("R1 mdc low in reset", mdc, 1'b0);
    chk("R1 oe low in reset", mdio_oe, 1'b0);
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    host_read(2'd0, d); chk("R1 control reset", d, 16'h1000);
    host_read(2'd1, d); chk("R1 wdata reset", d, 16'h0);
    host_read(2'd2, d); chk("R1 rdata reset", d, 16'h0);
    chk("R1 oe low after reset", mdio_oe, 1'b0);

    host_write(2'd1, 16'hA5C3);
    host_read(2'd1, d); chk("R2 wdata readback", d, 16'hA5C3);
    host_read(2'd3, d); chk("R2 unused address reads 0", d, 16'h0);

    rises = 0;
    host_write(2'd0, {3'b000, 1'b0, 2'd0, 5'd3, 5'd7});
    repeat (200) @(posedge clk);
    #1;
    host_read(2'd0, d); chk("R3 command 0 starts nothing", d, 16'h1000);
    host_write(2'd0, {3'b000, 1'b0, 2'd3, 5'd9, 5'd2});
    repeat (200) @(posedge clk);
    #1;
    host_read(2'd0, d); chk("R3 command 3 starts nothing", d, 16'h1000);
    chk("R3 no mdc activity", rises, 0);

    run_frame(1'b0, 5'h11, 5'h0A, 16'hBEEF, 16'h0, 1'b0); // R10 write data
    run_frame(1'b1, 5'h1F, 5'h00, 16'h0, 16'h8001, 1'b0); // R7 read
    run_frame(1'b1, 5'h00, 5'h1F, 16'h0, 16'h7E5A, 1'b1); // R8 busy write
    run_frame(1'b0, 5'h05, 5'h15, 16'h0001, 16'h0, 1'b1); // R10 with busy write

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

endmodule